// File: doc/BRIEF.md
# Interrupt Controller CPU Interface

This block is the processor-facing side of an interrupt controller. A distributor elsewhere on the chip holds the per-line enable, pending, trigger-type and priority state and presents it as flat vectors. From those vectors the block picks the best interrupt: the lowest numeric priority value wins, and a tie goes to the lowest line number. It raises a single request line towards the processor when that interrupt beats both the priority mask and the priority of the interrupt now being serviced.

Software talks to the block through a small register port. An acknowledge read claims the best interrupt. It returns the interrupt's 10-bit ID, makes its priority the running priority and sends the distributor a set-active request. For edge-triggered lines it also sends a pending-clear request. An end-of-interrupt write that names the running ID returns the block to idle. The idle state uses running priority 0x100, one step above every 8-bit priority value, and ID 1023, which also serves as the "nothing" answer.

The register port takes one access per cycle and never stalls, so there is no ready signal. Every access gets exactly one response, one cycle later. Reads of the ID and running-priority registers return the state before that access.

Top module: `icpu_top`

## Requirements
- R1: After reset the enable bit is 0, the mask reads 0xF0, the running priority (offset 0x14) reads 0x100, and irq_out is low.
- R2: Bit 0 of a write to offset 0x00 sets the interface enable, and a read of 0x00 returns it in bit 0 with all other bits 0.
- R3: A write to offset 0x04 stores bits 9:0 as the priority mask, and a read of 0x04 returns them with bits 31:10 as 0.
- R4: Offset 0x08 always reads 0. Writes to it are accepted without error and change nothing.
- R5: A line is a candidate when dist_en, its enable bit and its pending bit are all 1. Line i's priority is line_prio[8i+7:8i]. The best candidate has the lowest priority value, and a tie goes to the lowest index. A read of 0x18 returns its index, or 1023 if there is no candidate.
- R6: irq_out is 1 exactly when the interface is enabled, a candidate exists, and the best priority is numerically below both the mask and the running priority.
- R7: A read of 0x0C while irq_out is 1 returns the best ID. It also makes that line's priority the running priority, and in the response cycle set_active_valid pulses with set_active_id equal to the ID.
- R8: Such an acknowledge also pulses clr_pend_valid with clr_pend_id equal to the ID when line_edge of that line is 1. When line_edge is 0 it does not pulse.
- R9: A read of 0x0C while irq_out is 0 returns 1023, changes no state and produces no pulse.
- R10: A write to 0x10 whose bits 9:0 equal the running ID sets the running priority to 0x100 and the running ID to 1023.
- R11: A write to 0x10 whose bits 9:0 differ from the running ID changes nothing.
- R12: A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x14 or 0x18 is an error. So is a write to any offset other than 0x00, 0x04, 0x08 or 0x10. An error sets rsp_err, returns data 0 and changes no state.
- R13: rsp_valid is 1 in exactly the cycle after each cycle in which acc_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Byte offset |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Access was to an illegal offset or in an illegal direction |
| dist_en | input | 1 | Distributor global enable |
| line_en | input | NUM_IRQ | Per-line enable |
| line_pend | input | NUM_IRQ | Per-line pending |
| line_edge | input | NUM_IRQ | Per-line trigger type, 1 = edge |
| line_prio | input | NUM_IRQ*8 | Per-line priority, line i in bits 8i+7:8i |
| irq_out | output | 1 | Interrupt request to the processor |
| set_active_valid | output | 1 | Request to mark a line active |
| set_active_id | output | 10 | Line to mark active |
| clr_pend_valid | output | 1 | Request to clear a line's pending bit |
| clr_pend_id | output | 10 | Line whose pending bit to clear |

## Verification
The assertions assume that the distributor vectors hold steady from an acknowledge until its response cycle, so the pulses match the line that was arbitrated. They also assume that reset is held long enough to load the idle values. The bench changes the line vectors only on falling edges between register accesses. Whenever it acknowledges an interrupt, it retires that interrupt with a matching completion before it applies a new pattern. This keeps one active level at a time, as the block expects.

// File: rtl/icpu_pkg.sv
package icpu_pkg;
  localparam int ID_W   = 10;
  localparam int MASK_W = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam logic [ID_W-1:0] NO_ID = 10'd1023;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_BPT  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_ACK  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_EOI  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_RUN  = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_HPI  = 5'h18;
endpackage

// File: rtl/icpu_arb.sv
module icpu_arb
  import icpu_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int PRIO_W  = 8
) (
  input  logic                      dist_en,
  input  logic [NUM_IRQ-1:0]        line_en,
  input  logic [NUM_IRQ-1:0]        line_pend,
  input  logic [NUM_IRQ*PRIO_W-1:0] line_prio,
  output logic                      best_valid,
  output logic [ID_W-1:0]           best_id,
  output logic [PRIO_W-1:0]         best_prio
);
  logic [NUM_IRQ-1:0] qual;
  logic [PRIO_W-1:0]  prio_arr [NUM_IRQ];

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign qual[g]     = dist_en & line_en[g] & line_pend[g];
    assign prio_arr[g] = line_prio[g*PRIO_W +: PRIO_W];
  end

  // Ascending scan with strict compare: ties keep the lower index.
  always_comb begin
    best_valid = 1'b0;
    best_id    = NO_ID;
    best_prio  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (qual[i] && (!best_valid || prio_arr[i] < best_prio)) begin
        best_valid = 1'b1;
        best_id    = ID_W'(i);
        best_prio  = prio_arr[i];
      end
    end
  end
endmodule

// File: rtl/icpu_state.sv
module icpu_state
  import icpu_pkg::*;
#(
  parameter int PRIO_W = 8,
  localparam int RUN_W = PRIO_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr,
  input  logic               mask_wr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               ack_take,
  input  logic [ID_W-1:0]    ack_id,
  input  logic [PRIO_W-1:0]  ack_prio,
  input  logic               ack_edge,
  input  logic               eoi_wr,
  output logic               cpu_en,
  output logic [MASK_W-1:0]  prio_mask,
  output logic [RUN_W-1:0]   run_prio,
  output logic [ID_W-1:0]    run_id,
  output logic               sa_valid,
  output logic [ID_W-1:0]    sa_id,
  output logic               cp_valid,
  output logic [ID_W-1:0]    cp_id
);
  localparam logic [RUN_W-1:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  logic eoi_hit;
  assign eoi_hit = eoi_wr && (wdata[ID_W-1:0] == run_id);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_en    <= 1'b0;
      prio_mask <= MASK_W'(8'hF0);
      run_prio  <= IDLE_PRIO;
      run_id    <= NO_ID;
      sa_valid  <= 1'b0;
      sa_id     <= NO_ID;
      cp_valid  <= 1'b0;
      cp_id     <= NO_ID;
    end else begin
      sa_valid <= 1'b0;
      cp_valid <= 1'b0;
      if (ctrl_wr) cpu_en <= wdata[0];
      if (mask_wr) prio_mask <= wdata[MASK_W-1:0];
      if (ack_take) begin
        run_prio <= {1'b0, ack_prio};
        run_id   <= ack_id;
        sa_valid <= 1'b1;
        sa_id    <= ack_id;
        cp_valid <= ack_edge;
        cp_id    <= ack_id;
      end else if (eoi_hit) begin
        run_prio <= IDLE_PRIO;
        run_id   <= NO_ID;
      end
    end
  end
endmodule

// File: rtl/icpu_top.sv
module icpu_top
  import icpu_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  logic [4:0]                acc_addr,
  input  logic [31:0]               acc_wdata,
  output logic                      rsp_valid,
  output logic [31:0]               rsp_rdata,
  output logic                      rsp_err,
  input  logic                      dist_en,
  input  logic [NUM_IRQ-1:0]        line_en,
  input  logic [NUM_IRQ-1:0]        line_pend,
  input  logic [NUM_IRQ-1:0]        line_edge,
  input  logic [NUM_IRQ*PRIO_W-1:0] line_prio,
  output logic                      irq_out,
  output logic                      set_active_valid,
  output logic [9:0]                set_active_id,
  output logic                      clr_pend_valid,
  output logic [9:0]                clr_pend_id
);
  localparam int RUN_W = PRIO_W + 1;
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic              best_valid;
  logic [ID_W-1:0]   best_id;
  logic [PRIO_W-1:0] best_prio;
  logic              cpu_en;
  logic [MASK_W-1:0] prio_mask;
  logic [RUN_W-1:0]  run_prio;
  logic [ID_W-1:0]   run_id;

  icpu_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .dist_en    (dist_en),
    .line_en    (line_en),
    .line_pend  (line_pend),
    .line_prio  (line_prio),
    .best_valid (best_valid),
    .best_id    (best_id),
    .best_prio  (best_prio)
  );

  // Request: beats both the mask and the level being serviced.
  assign irq_out = cpu_en && best_valid
                && (MASK_W'(best_prio) < prio_mask)
                && ({1'b0, best_prio} < run_prio);

  // Access decode.
  logic rd_legal, wr_legal, acc_err;
  always_comb begin
    unique case (acc_addr)
      OFS_CTRL, OFS_MASK, OFS_BPT, OFS_ACK, OFS_RUN, OFS_HPI: rd_legal = 1'b1;
      default: rd_legal = 1'b0;
    endcase
    unique case (acc_addr)
      OFS_CTRL, OFS_MASK, OFS_BPT, OFS_EOI: wr_legal = 1'b1;
      default: wr_legal = 1'b0;
    endcase
  end
  assign acc_err = acc_valid && !(acc_write ? wr_legal : rd_legal);

  logic wr_ok, rd_ok;
  assign wr_ok = acc_valid && acc_write && wr_legal;
  assign rd_ok = acc_valid && !acc_write && rd_legal;

  logic ack_rd, ack_take, ack_edge;
  assign ack_rd   = rd_ok && (acc_addr == OFS_ACK);
  assign ack_take = ack_rd && irq_out;
  assign ack_edge = line_edge[best_id[IDX_W-1:0]];

  icpu_state #(.PRIO_W(PRIO_W)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (wr_ok && acc_addr == OFS_CTRL),
    .mask_wr   (wr_ok && acc_addr == OFS_MASK),
    .wdata     (acc_wdata),
    .ack_take  (ack_take),
    .ack_id    (best_id),
    .ack_prio  (best_prio),
    .ack_edge  (ack_edge),
    .eoi_wr    (wr_ok && acc_addr == OFS_EOI),
    .cpu_en    (cpu_en),
    .prio_mask (prio_mask),
    .run_prio  (run_prio),
    .run_id    (run_id),
    .sa_valid  (set_active_valid),
    .sa_id     (set_active_id),
    .cp_valid  (clr_pend_valid),
    .cp_id     (clr_pend_id)
  );

  // Read mux.
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (rd_ok) begin
      unique case (acc_addr)
        OFS_CTRL: rd_mux = DATA_W'(cpu_en);
        OFS_MASK: rd_mux = DATA_W'(prio_mask);
        OFS_ACK:  rd_mux = DATA_W'(ack_take ? best_id : NO_ID);
        OFS_RUN:  rd_mux = DATA_W'(run_prio);
        OFS_HPI:  rd_mux = DATA_W'(best_valid ? best_id : NO_ID);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_rdata <= rd_mux;
      rsp_err   <= acc_err;
    end
  end
endmodule

// File: rtl/icpu_chk.sv
module icpu_chk
  import icpu_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [4:0]        acc_addr,
  input logic [31:0]       acc_wdata,
  input logic              rsp_valid,
  input logic              acc_err,
  input logic              irq_out,
  input logic              cpu_en,
  input logic [PRIO_W:0]   run_prio,
  input logic [ID_W-1:0]   run_id,
  input logic              sa_valid,
  input logic [ID_W-1:0]   sa_id,
  input logic              cp_valid,
  input logic [ID_W-1:0]   cp_id
);
  localparam logic [PRIO_W:0] IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};

  a_r13_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);
  a_r13_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);
  a_r6_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> cpu_en);
  a_r7_active_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
    sa_valid |-> (run_prio != IDLE_PRIO && run_id == sa_id));
  a_r8_clr_with_active: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid |-> (sa_valid && cp_id == sa_id));
  a_r7_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_prio <= IDLE_PRIO);
  a_r11_eoi_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr == OFS_EOI && acc_wdata[ID_W-1:0] != run_id)
    |=> $stable(run_prio));
  a_r12_err_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> (!sa_valid && $stable(run_prio)));
endmodule

bind icpu_top icpu_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_addr  (acc_addr),
  .acc_wdata (acc_wdata),
  .rsp_valid (rsp_valid),
  .acc_err   (acc_err),
  .irq_out   (irq_out),
  .cpu_en    (cpu_en),
  .run_prio  (run_prio),
  .run_id    (run_id),
  .sa_valid  (set_active_valid),
  .sa_id     (set_active_id),
  .cp_valid  (clr_pend_valid),
  .cp_id     (clr_pend_id)
);

// File: tb/tb_icpu_top.sv
module tb_icpu_top;
  localparam int N  = 16;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0, acc_write = 1'b0;
  logic [4:0]    acc_addr = '0;
  logic [31:0]   acc_wdata = '0;
  logic          rsp_valid, rsp_err;
  logic [31:0]   rsp_rdata;
  logic          dist_en = 1'b0;
  logic [N-1:0]  line_en = '0, line_pend = '0, line_edge = '0;
  logic [N*PW-1:0] line_prio = '0;
  logic          irq_out, set_active_valid, clr_pend_valid;
  logic [9:0]    set_active_id, clr_pend_id;

  always #10 clk = ~clk;

  icpu_top #(.NUM_IRQ(N), .PRIO_W(PW)) dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] r_data; logic r_err, r_sa, r_cp; logic [9:0] r_said, r_cpid;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive on falling edge, capture response on the following falling edge.
  task automatic access(input logic wr, input logic [4:0] a, input logic [31:0] d);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0;
    r_data = rsp_rdata; r_err = rsp_err;
    r_sa = set_active_valid; r_said = set_active_id;
    r_cp = clr_pend_valid; r_cpid = clr_pend_id;
    check("R13 rsp_valid", {31'b0, rsp_valid}, 32'd1);
  endtask

  logic [31:0] seed = 32'h1234_5678;
  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  int exp_id, exp_pr;
  task automatic model_best();
    exp_id = 1023; exp_pr = 256;
    for (int i = 0; i < N; i++)
      if (dist_en && line_en[i] && line_pend[i] && int'(line_prio[i*PW +: PW]) < exp_pr) begin
        exp_id = i; exp_pr = int'(line_prio[i*PW +: PW]);
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int tmask;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_out", {31'b0, irq_out}, 0);
    access(0, 5'h00, 0); check("R1 enable", r_data, 0);
    access(0, 5'h04, 0); check("R1 mask", r_data, 32'hF0);
    access(0, 5'h14, 0); check("R1 running prio", r_data, 32'h100);
    access(0, 5'h18, 0); check("R1 highest pending", r_data, 1023);
    // R2 enable
    access(1, 5'h00, 32'hFFFF_FFFF); access(0, 5'h00, 0);
    check("R2 enable set", r_data, 1);
    access(1, 5'h00, 32'h2); access(0, 5'h00, 0);
    check("R2 enable cleared", r_data, 0);
    // R3 mask
    access(1, 5'h04, 32'hFFFF_FFFF); access(0, 5'h04, 0);
    check("R3 mask low bits", r_data, 32'h3FF);
    // R4 binary point
    access(1, 5'h08, 32'hFFFF_FFFF); check("R4 write no error", {31'b0, r_err}, 0);
    access(0, 5'h08, 0); check("R4 reads zero", r_data, 0);
    access(0, 5'h04, 0); check("R4 mask untouched", r_data, 32'h3FF);
    // R12 illegal accesses, then mask unchanged
    access(0, 5'h10, 0); check("R12 read eoi err", {31'b0, r_err}, 1);
    check("R12 err data", r_data, 0);
    access(1, 5'h0C, 0); check("R12 write ack err", {31'b0, r_err}, 1);
    access(1, 5'h18, 0); check("R12 write hpi err", {31'b0, r_err}, 1);
    access(1, 5'h04, 32'h0); check("R12 write mask ok", {31'b0, r_err}, 0);
    access(1, 5'h1C, 32'h3FF); check("R12 offset 1C err", {31'b0, r_err}, 1);
    access(0, 5'h02, 0); check("R12 offset 02 err", {31'b0, r_err}, 1);
    access(0, 5'h04, 0); check("R12 mask unchanged", r_data, 0);

    // R9 ack with nothing
    access(0, 5'h0C, 0); check("R9 ack none", r_data, 1023);
    check("R9 no pulse", {30'b0, r_sa, r_cp}, 0);

    // Directed preemption / R11 / R10
    access(1, 5'h00, 1); access(1, 5'h04, 32'h100);
    dist_en = 1; line_en = '1; line_pend = 16'h0028; line_edge = 16'h0008;
    line_prio = '1; line_prio[3*PW +: PW] = 8'h40; line_prio[5*PW +: PW] = 8'h40;
    #1 check("R6 irq pending", {31'b0, irq_out}, 1);
    access(0, 5'h0C, 0); check("R7 ack id", r_data, 3);
    check("R7 set active", {21'b0, r_sa, r_said}, {21'b0, 1'b1, 10'd3});
    check("R8 clr pend edge", {21'b0, r_cp, r_cpid}, {21'b0, 1'b1, 10'd3});
    line_pend[3] = 1'b0; #1;
    check("R6 equal prio blocked", {31'b0, irq_out}, 0);
    line_prio[5*PW +: PW] = 8'h20; #1;
    check("R6 lower prio preempts", {31'b0, irq_out}, 1);
    line_prio[5*PW +: PW] = 8'h40;
    access(1, 5'h10, 5); access(0, 5'h14, 0);
    check("R11 wrong eoi kept", r_data, 32'h40);
    access(1, 5'h10, 32'hFFFF_FC03); access(0, 5'h14, 0);
    check("R10 eoi restores", r_data, 32'h100);

    // Sweep
    for (int it = 0; it < 400; it++) begin
      seed = nxt(seed); line_en = seed[15:0]; line_pend = seed[31:16];
      seed = nxt(seed); line_edge = seed[15:0];
      dist_en = (seed[18:16] != 0);
      case (seed[21:20])
        2'd0: tmask = 0; 2'd1: tmask = 32'h20; 2'd2: tmask = 32'h60; default: tmask = 32'h100;
      endcase
      for (int i = 0; i < N; i++) begin
        seed = nxt(seed);
        line_prio[i*PW +: PW] = {1'b0, seed[1:0], 5'b0};
      end
      access(1, 5'h04, tmask);
      model_best();
      access(0, 5'h18, 0); check("R5 highest pending", r_data, exp_id);
      check("R6 irq", {31'b0, irq_out}, (exp_id != 1023 && exp_pr < tmask) ? 1 : 0);
      access(0, 5'h0C, 0);
      if (exp_id != 1023 && exp_pr < tmask) begin
        check("R7 ack id", r_data, exp_id);
        check("R7 active pulse", {21'b0, r_sa, r_said}, {21'b0, 1'b1, 10'(exp_id)});
        check("R8 clr pend", {31'b0, r_cp}, {31'b0, line_edge[exp_id]});
        access(0, 5'h14, 0); check("R7 running prio", r_data, exp_pr);
        access(1, 5'h10, exp_id); access(0, 5'h14, 0);
        check("R10 restore", r_data, 32'h100);
      end else begin
        check("R9 ack none", r_data, 1023);
        check("R9 no pulse", {30'b0, r_sa, r_cp}, 0);
        access(0, 5'h14, 0); check("R9 running unchanged", r_data, 32'h100);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule